// File: doc/BRIEF.md
# Tick-Driven Compare Timer

This block is a timer peripheral on a simple 32-bit register bus. Software controls it through trigger registers: one word starts the counter, one halts it and one zeroes it. A free-running base tick (`tickIn`) goes through a power-of-two prescaler and drives a counter. The counter's width can be 8, 16, 24 or 32 bits and is chosen at run time. The counter wraps to zero when it passes the top of the selected range.

Four compare channels each hold a compare value. Each channel has its own sticky event flag. The flag sets on the step where the counter moves onto that channel's compare value. It stays set until software writes zero to it. A compare value the counter has already passed does not fire until the counter wraps and comes back round to it. An enable mask, with set and clear aliases, picks which events drive the single interrupt output.

The register map uses byte offsets on an 8-bit address, with every word aligned. Writes happen when `busSel` and `busWr` are both high on a rising clock edge. Reads are combinational from `busAddr`. Unmapped and trigger offsets read as zero.

Top module: `evt_cmp_timer`

## Requirements
- R1: After reset every readable register reads 0: events, compare values, interrupt enable, mode (0 means 16-bit) and prescaler. `irqOut` is low.
- R2: Writing a word with bit 0 set to offset 0x00 starts the counter. With prescaler 0 and `tickIn` high, the counter steps once per clock, beginning on the edge after the start write. Event i (offset 0x10+4i) reads 1 from the edge on which the counter steps onto compare value i (offset 0x40+4i).
- R3: Writing bit 0 set to offset 0x04 halts the counter after that edge. A later start resumes counting from the held value. If start and halt coincide, halt wins.
- R4: Writing bit 0 set to offset 0x08 sets the counter and the prescaler phase to zero. It leaves the event flags unchanged, and the zeroing itself fires no event, even for a compare value of 0.
- R5: An event flag stays 1 until a write of value 0 to its offset. A nonzero write to an event offset has no effect. A hardware set wins over a clear in the same cycle.
- R6: A prescaler value n at offset 0x34 makes the counter step once every 2^n ticks while it runs, counted from the last zeroing. Written values above 9 are stored as 9. Cycles with `tickIn` low are not counted.
- R7: Mode at offset 0x30 selects the counter width: 0 for 16, 1 for 8, 2 for 24, 3 for 32 bits. The counter wraps from its top value to 0, and a step onto 0 by wrapping fires a compare value of 0. A compare value above the selected range never fires.
- R8: A compare value written below the current count fires only after the counter wraps and reaches it. Events already set stay set in the meantime.
- R9: A compare value written while the counter runs applies from the next counter step.
- R10: Offset 0x20 reads and writes the enable mask, with bit i for channel i. Offset 0x24 ORs the written bits into the mask, and offset 0x28 clears them; both aliases read back the mask. `irqOut` is the OR of all events whose enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickIn | input | 1 | Base tick enable feeding the prescaler |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | Write qualifier; a write happens on an edge with busSel and busWr high |
| busAddr | input | 8 | Byte address; only word-aligned addresses decode |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irqOut | output | 1 | OR of the enabled event flags |

## Verification
The compare path runs with a prescaler of 0 and also with a prescaler of 2. It runs with the counter stopped and resumed, zeroed while running, and with the tick held low. Each run checks the exact edge where a flag rises, which separates off-by-one errors in step timing and prescaler phase.

Two wrap runs are used. An 8-bit run has one compare value that was passed earlier and one that is out of range; it separates wrap-aware matching from matching on the low bits only. A full 16-bit run confirms that a compare value of 0 fires on the wrap. Interrupt patterns walk the enable mask through its set and clear aliases with two events pending, so a wrong mask bit or a wrong alias shows at the output.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int TMR_ADDR_W    = 8;
  localparam int TMR_CNT_W     = 32;
  localparam int TMR_CH_N      = 4;
  localparam int TMR_PRESC_MAX = 9;

  // Word indices (byte offset / 4) of the register map
  localparam int WIX_START  = 0;
  localparam int WIX_STOP   = 1;
  localparam int WIX_CLEAR  = 2;
  localparam int WIX_EVT0   = 4;
  localparam int WIX_IEN    = 8;
  localparam int WIX_IENSET = 9;
  localparam int WIX_IENCLR = 10;
  localparam int WIX_MODE   = 12;
  localparam int WIX_PRESC  = 13;
  localparam int WIX_CC0    = 16;

  typedef enum logic [1:0] {
    WM_16 = 2'd0,
    WM_8  = 2'd1,
    WM_24 = 2'd2,
    WM_32 = 2'd3
  } tmr_width_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic clear;
  } tmr_task_t;

  function automatic int widthBits(tmr_width_e m);
    case (m)
      WM_8:    return 8;
      WM_16:   return 16;
      WM_24:   return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NUM_CH    = TMR_CH_N,
  parameter int CNT_W     = TMR_CNT_W,
  parameter int PRESC_MAX = TMR_PRESC_MAX,
  localparam int PRESC_W  = $clog2(PRESC_MAX + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           tickIn,
  input  tmr_task_t                      taskStb,
  input  tmr_width_e                     widthSel,
  input  logic [PRESC_W-1:0]             prescSel,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   ccVal,
  output logic [NUM_CH-1:0]              matchOut
);

  localparam int PDIV_W = (PRESC_MAX > 0) ? PRESC_MAX : 1;

  logic              runQ;
  logic [PDIV_W-1:0] prescCnt;
  logic [PDIV_W-1:0] pMask;
  logic              prescHit;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  nextCnt;
  logic [CNT_W-1:0]  wMask;
  logic              advance;

  // Mask for the selected counter width
  always_comb begin
    int bits;
    bits = widthBits(widthSel);
    if (bits >= CNT_W) wMask = '1;
    else               wMask = CNT_W'((64'd1 << bits) - 64'd1);
  end

  // Prescaler: step when the low n bits of the tick count are all ones
  assign pMask    = PDIV_W'((64'd1 << prescSel) - 64'd1);
  assign prescHit = ((prescCnt & pMask) == pMask);
  assign advance  = runQ && tickIn && prescHit;
  assign nextCnt  = (cntQ + CNT_W'(1)) & wMask;

  // Run state: halt has priority over start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              runQ <= 1'b0;
    else if (taskStb.stop)  runQ <= 1'b0;
    else if (taskStb.start) runQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 prescCnt <= '0;
    else if (taskStb.clear)    prescCnt <= '0;
    else if (runQ && tickIn)   prescCnt <= prescCnt + PDIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= '0;
    else if (taskStb.clear) cntQ <= '0;
    else if (advance)       cntQ <= nextCnt;
  end

  // One compare lane per channel: fires only on a real counter step
  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    assign matchOut[g] = advance && !taskStb.clear && (nextCnt == ccVal[g]);
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !taskStb.clear) |=> $stable(cntQ)); // R3
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    taskStb.stop |=> !runQ); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    taskStb.clear |=> (cntQ == '0)); // R4
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !taskStb.clear && cntQ == wMask) |=> (cntQ == '0)); // R7

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W    = TMR_ADDR_W,
  parameter int NUM_CH    = TMR_CH_N,
  parameter int CNT_W     = TMR_CNT_W,
  parameter int PRESC_MAX = TMR_PRESC_MAX,
  parameter int DATA_W    = 32,
  localparam int PRESC_W  = $clog2(PRESC_MAX + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWr,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             busRdata,
  input  logic [NUM_CH-1:0]             matchIn,
  output tmr_task_t                     taskStb,
  output tmr_width_e                    widthSel,
  output logic [PRESC_W-1:0]            prescSel,
  output logic [NUM_CH-1:0][CNT_W-1:0]  ccVal,
  output logic                          irqOut
);

  localparam int IX_W = ADDR_W - 2;
  localparam logic [IX_W-1:0] IX_START  = IX_W'(WIX_START);
  localparam logic [IX_W-1:0] IX_STOP   = IX_W'(WIX_STOP);
  localparam logic [IX_W-1:0] IX_CLEAR  = IX_W'(WIX_CLEAR);
  localparam logic [IX_W-1:0] IX_IEN    = IX_W'(WIX_IEN);
  localparam logic [IX_W-1:0] IX_IENSET = IX_W'(WIX_IENSET);
  localparam logic [IX_W-1:0] IX_IENCLR = IX_W'(WIX_IENCLR);
  localparam logic [IX_W-1:0] IX_MODE   = IX_W'(WIX_MODE);
  localparam logic [IX_W-1:0] IX_PRESC  = IX_W'(WIX_PRESC);
  localparam logic [PRESC_W-1:0] PRESC_LIM = PRESC_W'(PRESC_MAX);

  logic [IX_W-1:0]    wordIx;
  logic               wrHit;
  logic [NUM_CH-1:0]  evtQ;
  logic [NUM_CH-1:0]  ienQ;
  logic [NUM_CH-1:0]  evtClrHit;
  logic [NUM_CH-1:0]  ccWrHit;
  logic [PRESC_W-1:0] prescWr;

  assign wordIx = busAddr[ADDR_W-1:2];
  assign wrHit  = busSel && busWr && (busAddr[1:0] == 2'b00);

  // Trigger strobes, active in the cycle of the write
  assign taskStb.start = wrHit && (wordIx == IX_START) && busWdata[0];
  assign taskStb.stop  = wrHit && (wordIx == IX_STOP)  && busWdata[0];
  assign taskStb.clear = wrHit && (wordIx == IX_CLEAR) && busWdata[0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign evtClrHit[g] = wrHit && (wordIx == IX_W'(WIX_EVT0 + g)) && (busWdata == '0);
    assign ccWrHit[g]   = wrHit && (wordIx == IX_W'(WIX_CC0 + g));
  end

  assign prescWr = (busWdata[PRESC_W-1:0] > PRESC_LIM) ? PRESC_LIM : busWdata[PRESC_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthSel <= WM_16;
      prescSel <= '0;
      ienQ     <= '0;
    end else if (wrHit) begin
      if (wordIx == IX_MODE)   widthSel <= tmr_width_e'(busWdata[1:0]);
      if (wordIx == IX_PRESC)  prescSel <= prescWr;
      if (wordIx == IX_IEN)    ienQ <= busWdata[NUM_CH-1:0];
      if (wordIx == IX_IENSET) ienQ <= ienQ | busWdata[NUM_CH-1:0];
      if (wordIx == IX_IENCLR) ienQ <= ienQ & ~busWdata[NUM_CH-1:0];
    end
  end

  // Sticky events and compare values; a hardware set beats a software clear
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             evtQ[g] <= 1'b0;
      else if (matchIn[g])   evtQ[g] <= 1'b1;
      else if (evtClrHit[g]) evtQ[g] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           ccVal[g] <= '0;
      else if (ccWrHit[g]) ccVal[g] <= busWdata[CNT_W-1:0];
    end

    AST_EVT_FROM_MATCH: assert property (@(posedge clk) disable iff (!rstN)
      $rose(evtQ[g]) |-> $past(matchIn[g])); // R2
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (evtQ[g] && !evtClrHit[g]) |=> evtQ[g]); // R5
  end

  always_comb begin
    busRdata = '0;
    if (busAddr[1:0] == 2'b00) begin
      if (wordIx == IX_IEN || wordIx == IX_IENSET || wordIx == IX_IENCLR)
        busRdata[NUM_CH-1:0] = ienQ;
      if (wordIx == IX_MODE)  busRdata[1:0] = widthSel;
      if (wordIx == IX_PRESC) busRdata[PRESC_W-1:0] = prescSel;
      for (int i = 0; i < NUM_CH; i++) begin
        if (wordIx == IX_W'(WIX_EVT0 + i)) busRdata[0] = evtQ[i];
        if (wordIx == IX_W'(WIX_CC0 + i))  busRdata[CNT_W-1:0] = ccVal[i];
      end
    end
  end

  assign irqOut = |(evtQ & ienQ);

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    prescSel <= PRESC_LIM); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (ienQ == '0) |-> !irqOut); // R10

endmodule

// File: rtl/evt_cmp_timer.sv
module evt_cmp_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W    = TMR_ADDR_W,
  parameter int NUM_CH    = TMR_CH_N,
  parameter int CNT_W     = TMR_CNT_W,
  parameter int PRESC_MAX = TMR_PRESC_MAX
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut
);

  localparam int PRESC_W = $clog2(PRESC_MAX + 1);

  tmr_task_t                    taskStb;
  tmr_width_e                   widthSel;
  logic [PRESC_W-1:0]           prescSel;
  logic [NUM_CH-1:0][CNT_W-1:0] ccVal;
  logic [NUM_CH-1:0]            matchVec;

  tmr_ctrl #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CNT_W(CNT_W),
    .PRESC_MAX(PRESC_MAX), .DATA_W(32)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .matchIn(matchVec), .taskStb(taskStb), .widthSel(widthSel),
    .prescSel(prescSel), .ccVal(ccVal), .irqOut(irqOut)
  );

  tmr_datapath #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRESC_MAX(PRESC_MAX)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .tickIn(tickIn),
    .taskStb(taskStb), .widthSel(widthSel), .prescSel(prescSel),
    .ccVal(ccVal), .matchOut(matchVec)
  );

endmodule

// File: tb/test_evt_cmp_timer.sv
module test_evt_cmp_timer;

  localparam logic [7:0] A_START = 8'h00, A_STOP = 8'h04, A_CLEAR = 8'h08;
  localparam logic [7:0] A_EVT = 8'h10, A_IEN = 8'h20, A_IENSET = 8'h24, A_IENCLR = 8'h28;
  localparam logic [7:0] A_MODE = 8'h30, A_PRESC = 8'h34, A_CC = 8'h40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b1;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  evt_cmp_timer i_evt_cmp_timer (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkReg(input string req, input string what, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, what, v, exp);
  endtask

  task automatic prep();
    wr(A_STOP, 1);
    wr(A_CLEAR, 1);
    for (int i = 0; i < 4; i++) wr(A_EVT + 8'(4 * i), 0);
    for (int i = 0; i < 4; i++) wr(A_CC + 8'(4 * i), 0);
    wr(A_MODE, 0);
    wr(A_PRESC, 0);
    wr(A_IENCLR, 32'hF);
    tickIn = 1'b1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      checkReg("R1", "event after reset", A_EVT + 8'(4 * i), 0);
      checkReg("R1", "cc after reset", A_CC + 8'(4 * i), 0);
    end
    checkReg("R1", "ien after reset", A_IEN, 0);
    checkReg("R1", "mode after reset", A_MODE, 0);
    checkReg("R1", "presc after reset", A_PRESC, 0);
    check("R1", "irq after reset", 32'(irqOut), 0);
  endtask

  task automatic t_basic();
    prep();
    wr(A_CC, 5);
    wr(A_START, 1);
    tick(4);
    checkReg("R2", "evt0 one step before match", A_EVT, 0);
    tick(1);
    checkReg("R2", "evt0 on match step", A_EVT, 1);
    check("R2", "irq masked", 32'(irqOut), 0);
  endtask

  task automatic t_stop();
    prep();
    wr(A_CC, 10);
    wr(A_START, 1);
    tick(3);
    wr(A_STOP, 1);          // counter holds at 4
    tick(20);
    checkReg("R3", "no event while halted", A_EVT, 0);
    wr(A_START, 1);
    tick(5);
    checkReg("R3", "evt0 before resumed match", A_EVT, 0);
    tick(1);
    checkReg("R3", "evt0 after resume from held count", A_EVT, 1);
  endtask

  task automatic t_clear();
    prep();
    wr(A_CC, 3);
    wr(A_CC + 8'd8, 32'd0);
    wr(A_START, 1);
    tick(5);
    wr(A_CLEAR, 1);          // counter back to 0
    checkReg("R4", "evt0 kept after clear", A_EVT, 1);
    checkReg("R4", "no event from clear with cc=0", A_EVT + 8'd8, 0);
    wr(A_EVT, 0);            // counter now 1
    tick(1);
    checkReg("R4", "evt0 one step before match after clear", A_EVT, 0);
    tick(1);
    checkReg("R4", "evt0 fires counting from zero", A_EVT, 1);
  endtask

  task automatic t_sticky();
    prep();
    wr(A_CC, 2);
    wr(A_START, 1);
    tick(4);
    wr(A_STOP, 1);
    tick(3);
    checkReg("R5", "evt0 stays set", A_EVT, 1);
    wr(A_EVT, 32'h2);
    checkReg("R5", "nonzero write ignored", A_EVT, 1);
    wr(A_EVT, 0);
    checkReg("R5", "zero write clears", A_EVT, 0);
    tick(5);
    checkReg("R5", "stays clear", A_EVT, 0);
  endtask

  task automatic t_presc();
    prep();
    wr(A_PRESC, 2);
    checkReg("R6", "presc readback", A_PRESC, 2);
    wr(A_CC, 3);
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    tick(11);
    checkReg("R6", "evt0 before 12 ticks", A_EVT, 0);
    tick(1);
    checkReg("R6", "evt0 after 12 ticks at div 4", A_EVT, 1);
    wr(A_PRESC, 15);
    checkReg("R6", "presc clamps to 9", A_PRESC, 9);
    // gated tick
    prep();
    wr(A_CC, 3);
    wr(A_START, 1);
    tickIn = 1'b0;
    tick(10);
    checkReg("R6", "no step with tick low", A_EVT, 0);
    tickIn = 1'b1;
    tick(2);
    checkReg("R6", "evt0 before third tick", A_EVT, 0);
    tick(1);
    checkReg("R6", "evt0 after third tick", A_EVT, 1);
  endtask

  task automatic t_wrap8();
    prep();
    wr(A_MODE, 1);
    checkReg("R7", "mode readback", A_MODE, 1);
    wr(A_CC, 5);
    wr(A_CC + 8'd8, 32'h103);
    wr(A_START, 1);
    tick(9);
    wr(A_CC + 8'd4, 3);      // counter already at 10
    tick(248);
    checkReg("R8", "passed cc not yet fired", A_EVT + 8'd4, 0);
    checkReg("R8", "evt0 kept meanwhile", A_EVT, 1);
    tick(1);
    checkReg("R8", "passed cc fires after 8-bit wrap", A_EVT + 8'd4, 1);
    checkReg("R7", "out-of-range cc never fires", A_EVT + 8'd8, 0);
  endtask

  task automatic t_wrap16();
    prep();
    wr(A_CC, 32'h10000);
    wr(A_CC + 8'd12, 0);
    wr(A_START, 1);
    tick(65535);
    checkReg("R7", "cc=0 before 16-bit wrap", A_EVT + 8'd12, 0);
    tick(1);
    checkReg("R7", "cc=0 fires on 16-bit wrap", A_EVT + 8'd12, 1);
    checkReg("R7", "cc above 16 bits never fires", A_EVT, 0);
  endtask

  task automatic t_live_cc();
    prep();
    wr(A_CC, 100);
    wr(A_START, 1);
    tick(9);
    wr(A_CC, 12);            // counter 10
    tick(1);
    checkReg("R9", "new cc before match", A_EVT, 0);
    tick(1);
    checkReg("R9", "new cc used at once", A_EVT, 1);
  endtask

  task automatic t_irq();
    prep();
    wr(A_CC, 2);
    wr(A_CC + 8'd8, 3);
    wr(A_START, 1);
    tick(5);
    wr(A_STOP, 1);
    check("R10", "irq with mask 0", 32'(irqOut), 0);
    wr(A_IENSET, 32'h4);
    check("R10", "irq from evt2", 32'(irqOut), 1);
    checkReg("R10", "ien after set", A_IEN, 32'h4);
    wr(A_IENSET, 32'h1);
    checkReg("R10", "set alias ORs", A_IENSET, 32'h5);
    wr(A_IENCLR, 32'h4);
    checkReg("R10", "clear alias", A_IENCLR, 32'h1);
    check("R10", "irq from evt0 only", 32'(irqOut), 1);
    wr(A_EVT, 0);
    check("R10", "irq drops when enabled event cleared", 32'(irqOut), 0);
    wr(A_IEN, 32'hA);
    checkReg("R10", "direct write", A_IEN, 32'hA);
    check("R10", "irq stays low, evt2 masked", 32'(irqOut), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rstN = 1'b1;
        t_reset();
        t_basic();
        t_stop();
        t_clear();
        t_sticky();
        t_presc();
        t_wrap8();
        t_wrap16();
        t_live_cc();
        t_irq();
      end
      begin
        repeat (150000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule